// File: doc/BRIEF.md
# Two-Stage Address Translation Sequencer

This block steers one address translation at a time through up to three external services: a table walker that resolves stage 1 and stage 2, and a debug checker. A request carries a virtual address, an access kind, direction, size and alignment. The block sends a stage-1 lookup to the walker. When stage 1 returns without a fault and stage 2 is both present and switched on, it sends a stage-2 lookup on the intermediate address. It then applies the stage-2 fault checks itself, optionally asks the debug checker, and presents the final physical address, the fault code and the widened virtual address.

A request may also be marked as a stage-2 lookup made for a stage-1 table fetch. In that case stage 1 is skipped, and the address is treated as an intermediate address. Such lookups are presented to the walker as aligned 8-byte accesses. They can draw a permission fault when they land on device memory while table-walk protection is set.

Every data channel uses valid/ready. A request is taken only in the idle state, so `req_ready` is back-pressure for the whole translation. Walker and debug requests hold their fields until they are accepted. The result holds until `res_ready`. The configuration pins are plain levels and must stay steady while a translation is in flight.

Top module: `xlate_seq`

## Requirements
- R1: `req_ready` is high only when no translation is in flight. At most one of walker request, debug request and result valid is high at a time. A walker request holds its fields until `wk_req_ready`.
- R2: Once `res_valid` rises, it stays high with unchanged `res_paddr`, `res_ns`, `res_fault` and `res_vaddr` until `res_ready`.
- R3: No stage-2 lookup is issued when the stage-1 fault code is non-zero, when the access kind is 3 (nested-virtualization register), or when `cfg_s2_present` is 0. The result is then the stage-1 address, secure-state bit and fault.
- R4: With stage 2 present, a lookup is issued when `cfg_s2_virt_en` or `cfg_s2_dflt_cache` is 1. When both are 0, the stage-1 result passes through.
- R5: The stage-2 lookup (`wk_req_stage2`=1) carries the stage-1 output address zero-extended in `wk_req_addr`, and the stage-1 secure-state bit in `wk_req_ns`. A stage-1 lookup carries the zero-extended virtual address.
- R6: Stage-2 alignment check. With no walker fault, a device hit gives fault code 2 when the access is unaligned and not kind 1 (instruction fetch), or when the kind is 2 (zero-by-line). This check takes precedence over R7 to R9.
- R7: With no earlier fault, a stage-2 response with `wk_rsp_deny`=1 gives fault code 3.
- R8: With no earlier fault, a kind-1 fetch that hits device memory at stage 2 gives fault code 4. This check is not made for table-walk lookups.
- R9: With no earlier fault, a table-walk lookup that hits device memory while `cfg_walk_protect`=1 gives fault code 3.
- R10: A request with `req_table_walk`=1 issues no stage-1 lookup. Its walker lookup shows `wk_req_s1walk`=1, `wk_req_aligned`=1 and `wk_req_size`=8. With stage 2 skipped, the result address is the request address.
- R11: The debug check is requested only when the fault code is 0 and the kind is not 4 (table walk), 5 (instruction-cache maintenance) or 6 (address-translate). Its returned code becomes the result fault.
- R12: `res_vaddr` equals `req_vaddr` zero-extended to 64 bits.
- R13: The device and deny flags of a stage-1 response never change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_s2_present | input | 1 | Stage 2 exists in this regime |
| cfg_s2_virt_en | input | 1 | Stage-2 virtualization enable |
| cfg_s2_dflt_cache | input | 1 | Default-cacheable control (also enables stage 2) |
| cfg_walk_protect | input | 1 | Protect table-walk lookups from device memory |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle, request accepted |
| req_vaddr | input | VA_W | Virtual (or intermediate, for walk lookups) address |
| req_kind | input | 3 | Access kind code |
| req_write | input | 1 | Write access |
| req_aligned | input | 1 | Access is aligned |
| req_size | input | SZ_W | Access size in bytes |
| req_ns | input | 1 | Secure-state bit for table-walk lookups |
| req_table_walk | input | 1 | Request is a stage-2 lookup for a stage-1 table fetch |
| wk_req_valid | output | 1 | Walker request valid |
| wk_req_ready | input | 1 | Walker accepts request |
| wk_req_stage2 | output | 1 | 1 = stage-2 lookup, 0 = stage-1 |
| wk_req_addr | output | WK_ADDR_W | Lookup input address |
| wk_req_ns | output | 1 | Secure-state bit of the lookup |
| wk_req_kind | output | 3 | Access kind |
| wk_req_write | output | 1 | Write access |
| wk_req_aligned | output | 1 | Effective alignment |
| wk_req_size | output | SZ_W | Effective size in bytes |
| wk_req_s1walk | output | 1 | Lookup made for a stage-1 table fetch |
| wk_rsp_valid | input | 1 | Walker response valid |
| wk_rsp_ready | output | 1 | Block waiting for a walker response |
| wk_rsp_addr | input | PA_W | Output address of the lookup |
| wk_rsp_ns | input | 1 | Output secure-state bit |
| wk_rsp_fault | input | 3 | Walker fault code, 0 = none |
| wk_rsp_device | input | 1 | Target is device memory |
| wk_rsp_deny | input | 1 | Permission comparator denies the access |
| dbg_req_valid | output | 1 | Debug check request valid |
| dbg_req_ready | input | 1 | Debug checker accepts request |
| dbg_req_vaddr | output | VA_W | Virtual address to check |
| dbg_req_kind | output | 3 | Access kind |
| dbg_req_write | output | 1 | Write access |
| dbg_req_size | output | SZ_W | Access size |
| dbg_rsp_valid | input | 1 | Debug response valid |
| dbg_rsp_ready | output | 1 | Block waiting for debug response |
| dbg_rsp_fault | input | 3 | Debug fault code, 0 = none |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_paddr | output | PA_W | Final output address |
| res_ns | output | 1 | Final secure-state bit |
| res_fault | output | 3 | Final fault code, 0 = none |
| res_vaddr | output | OUT_VA_W | Zero-extended request address |

## Verification
The properties watch the channel rules on every cycle. These are exclusive ownership of the one in-flight translation, held walker requests, a result that does not drift while stalled, the fixed shape of table-walk lookups, the exemption of three access kinds from debug requests, and the zero upper bits of the reported address. Only the bench's scenarios can show which path a translation takes. That covers whether stage 2 is skipped or taken, the order in which the alignment, permission, fetch-from-device and walk-protection checks override each other, which fault code wins, and that stage-1 device or deny flags have no effect on the result.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int FLT_W = 3;
  localparam int KIND_W = 3;

  // access kinds
  localparam logic [KIND_W-1:0] ACC_NORMAL     = 3'd0;
  localparam logic [KIND_W-1:0] ACC_IFETCH     = 3'd1;
  localparam logic [KIND_W-1:0] ACC_ZERO_LINE  = 3'd2;
  localparam logic [KIND_W-1:0] ACC_NV_REG     = 3'd3;
  localparam logic [KIND_W-1:0] ACC_TABLE_WALK = 3'd4;
  localparam logic [KIND_W-1:0] ACC_IC_MAINT   = 3'd5;
  localparam logic [KIND_W-1:0] ACC_ADDR_XLATE = 3'd6;

  // fault codes raised inside the block
  localparam logic [FLT_W-1:0] FLT_NONE     = 3'd0;
  localparam logic [FLT_W-1:0] FLT_ALIGN    = 3'd2;
  localparam logic [FLT_W-1:0] FLT_PERM     = 3'd3;
  localparam logic [FLT_W-1:0] FLT_EXEC_DEV = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_S1_REQ, ST_S1_WAIT, ST_S2_REQ,
    ST_S2_WAIT, ST_DBG_REQ, ST_DBG_WAIT, ST_DONE
  } seq_state_e;
endpackage

// File: rtl/xlate_s2_check.sv
module xlate_s2_check
  import xlate_pkg::*;
(
  input  logic [FLT_W-1:0]  walk_fault,
  input  logic              device,
  input  logic              deny,
  input  logic [KIND_W-1:0] kind,
  input  logic              aligned_eff,
  input  logic              table_walk,
  input  logic              walk_protect,
  output logic [FLT_W-1:0]  fault
);
  logic misalign_hit;
  assign misalign_hit = device &&
                        ((!aligned_eff && kind != ACC_IFETCH) || kind == ACC_ZERO_LINE);

  // ordered checks: each applies only when nothing earlier faulted
  always_comb begin
    fault = walk_fault;
    if (fault == FLT_NONE && misalign_hit)
      fault = FLT_ALIGN;
    if (fault == FLT_NONE && deny)
      fault = FLT_PERM;
    if (fault == FLT_NONE && !table_walk && device && kind == ACC_IFETCH)
      fault = FLT_EXEC_DEV;
    if (fault == FLT_NONE && table_walk && walk_protect && device)
      fault = FLT_PERM;
  end
endmodule

// File: rtl/xlate_route.sv
module xlate_route
  import xlate_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  input  logic [FLT_W-1:0]  s1_fault,
  input  logic [FLT_W-1:0]  post_fault,
  input  logic              s2_present,
  input  logic              virt_en,
  input  logic              dflt_cache,
  output logic              s2_go,
  output logic              dbg_go
);
  logic dbg_exempt;
  assign dbg_exempt = (kind == ACC_TABLE_WALK) || (kind == ACC_IC_MAINT) ||
                      (kind == ACC_ADDR_XLATE);
  assign s2_go  = (s1_fault == FLT_NONE) && (kind != ACC_NV_REG) && s2_present &&
                  (virt_en || dflt_cache);
  assign dbg_go = (post_fault == FLT_NONE) && !dbg_exempt;
endmodule

// File: rtl/xlate_seq.sv
module xlate_seq
  import xlate_pkg::*;
#(
  parameter int VA_W       = 48,
  parameter int PA_W       = 52,
  parameter int OUT_VA_W   = 64,
  parameter int WK_ADDR_W  = 64,
  parameter int SZ_W       = 8,
  parameter int WALK_BYTES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_s2_present,
  input  logic                 cfg_s2_virt_en,
  input  logic                 cfg_s2_dflt_cache,
  input  logic                 cfg_walk_protect,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VA_W-1:0]      req_vaddr,
  input  logic [2:0]           req_kind,
  input  logic                 req_write,
  input  logic                 req_aligned,
  input  logic [SZ_W-1:0]      req_size,
  input  logic                 req_ns,
  input  logic                 req_table_walk,
  output logic                 wk_req_valid,
  input  logic                 wk_req_ready,
  output logic                 wk_req_stage2,
  output logic [WK_ADDR_W-1:0] wk_req_addr,
  output logic                 wk_req_ns,
  output logic [2:0]           wk_req_kind,
  output logic                 wk_req_write,
  output logic                 wk_req_aligned,
  output logic [SZ_W-1:0]      wk_req_size,
  output logic                 wk_req_s1walk,
  input  logic                 wk_rsp_valid,
  output logic                 wk_rsp_ready,
  input  logic [PA_W-1:0]      wk_rsp_addr,
  input  logic                 wk_rsp_ns,
  input  logic [2:0]           wk_rsp_fault,
  input  logic                 wk_rsp_device,
  input  logic                 wk_rsp_deny,
  output logic                 dbg_req_valid,
  input  logic                 dbg_req_ready,
  output logic [VA_W-1:0]      dbg_req_vaddr,
  output logic [2:0]           dbg_req_kind,
  output logic                 dbg_req_write,
  output logic [SZ_W-1:0]      dbg_req_size,
  input  logic                 dbg_rsp_valid,
  output logic                 dbg_rsp_ready,
  input  logic [2:0]           dbg_rsp_fault,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [PA_W-1:0]      res_paddr,
  output logic                 res_ns,
  output logic [2:0]           res_fault,
  output logic [OUT_VA_W-1:0]  res_vaddr
);
  localparam logic [SZ_W-1:0] WALK_SZ = SZ_W'(WALK_BYTES);

  seq_state_e          state_q;
  logic [KIND_W-1:0]   kind_q;
  logic                write_q, aligned_q, walk_q, ns_q;
  logic [SZ_W-1:0]     size_q;
  logic [VA_W-1:0]     va_q;
  logic [PA_W-1:0]     pa_q;
  logic [FLT_W-1:0]    flt_q;

  logic [FLT_W-1:0]    s2_flt;
  logic [FLT_W-1:0]    rt_s1_fault, rt_post_fault;
  logic [KIND_W-1:0]   rt_kind;
  logic                s2_go, dbg_go;
  logic                aligned_eff;

  assign aligned_eff = walk_q | aligned_q;

  xlate_s2_check u_s2chk (
    .walk_fault   (wk_rsp_fault),
    .device       (wk_rsp_device),
    .deny         (wk_rsp_deny),
    .kind         (kind_q),
    .aligned_eff  (aligned_eff),
    .table_walk   (walk_q),
    .walk_protect (cfg_walk_protect),
    .fault        (s2_flt)
  );

  // route inputs depend on where the decision is being taken
  always_comb begin
    rt_kind       = kind_q;
    rt_s1_fault   = wk_rsp_fault;
    rt_post_fault = wk_rsp_fault;
    case (state_q)
      ST_IDLE: begin
        rt_kind       = req_kind;
        rt_s1_fault   = FLT_NONE;
        rt_post_fault = FLT_NONE;
      end
      ST_S2_WAIT: rt_post_fault = s2_flt;
      default: ;
    endcase
  end

  xlate_route u_route (
    .kind       (rt_kind),
    .s1_fault   (rt_s1_fault),
    .post_fault (rt_post_fault),
    .s2_present (cfg_s2_present),
    .virt_en    (cfg_s2_virt_en),
    .dflt_cache (cfg_s2_dflt_cache),
    .s2_go      (s2_go),
    .dbg_go     (dbg_go)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      kind_q    <= '0;
      write_q   <= 1'b0;
      aligned_q <= 1'b0;
      walk_q    <= 1'b0;
      ns_q      <= 1'b0;
      size_q    <= '0;
      va_q      <= '0;
      pa_q      <= '0;
      flt_q     <= FLT_NONE;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          kind_q    <= req_kind;
          write_q   <= req_write;
          aligned_q <= req_aligned;
          walk_q    <= req_table_walk;
          size_q    <= req_size;
          va_q      <= req_vaddr;
          pa_q      <= PA_W'(req_vaddr);
          ns_q      <= req_ns;
          flt_q     <= FLT_NONE;
          if (!req_table_walk)  state_q <= ST_S1_REQ;
          else if (s2_go)       state_q <= ST_S2_REQ;
          else if (dbg_go)      state_q <= ST_DBG_REQ;
          else                  state_q <= ST_DONE;
        end
        ST_S1_REQ: if (wk_req_ready) state_q <= ST_S1_WAIT;
        ST_S1_WAIT: if (wk_rsp_valid) begin
          pa_q  <= wk_rsp_addr;
          ns_q  <= wk_rsp_ns;
          flt_q <= wk_rsp_fault;
          if (s2_go)       state_q <= ST_S2_REQ;
          else if (dbg_go) state_q <= ST_DBG_REQ;
          else             state_q <= ST_DONE;
        end
        ST_S2_REQ: if (wk_req_ready) state_q <= ST_S2_WAIT;
        ST_S2_WAIT: if (wk_rsp_valid) begin
          pa_q  <= wk_rsp_addr;
          ns_q  <= wk_rsp_ns;
          flt_q <= s2_flt;
          state_q <= dbg_go ? ST_DBG_REQ : ST_DONE;
        end
        ST_DBG_REQ: if (dbg_req_ready) state_q <= ST_DBG_WAIT;
        ST_DBG_WAIT: if (dbg_rsp_valid) begin
          flt_q   <= dbg_rsp_fault;
          state_q <= ST_DONE;
        end
        ST_DONE: if (res_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready      = (state_q == ST_IDLE);
  assign wk_req_valid   = (state_q == ST_S1_REQ) || (state_q == ST_S2_REQ);
  assign wk_req_stage2  = (state_q == ST_S2_REQ);
  assign wk_req_addr    = wk_req_stage2 ? WK_ADDR_W'(pa_q) : WK_ADDR_W'(va_q);
  assign wk_req_ns      = ns_q;
  assign wk_req_kind    = kind_q;
  assign wk_req_write   = write_q;
  assign wk_req_aligned = aligned_eff;
  assign wk_req_size    = walk_q ? WALK_SZ : size_q;
  assign wk_req_s1walk  = walk_q;
  assign wk_rsp_ready   = (state_q == ST_S1_WAIT) || (state_q == ST_S2_WAIT);

  assign dbg_req_valid  = (state_q == ST_DBG_REQ);
  assign dbg_req_vaddr  = va_q;
  assign dbg_req_kind   = kind_q;
  assign dbg_req_write  = write_q;
  assign dbg_req_size   = size_q;
  assign dbg_rsp_ready  = (state_q == ST_DBG_WAIT);

  assign res_valid      = (state_q == ST_DONE);
  assign res_paddr      = pa_q;
  assign res_ns         = ns_q;
  assign res_fault      = flt_q;
  assign res_vaddr      = OUT_VA_W'(va_q);
endmodule

// File: rtl/xlate_seq_chk.sv
module xlate_seq_chk #(
  parameter int VA_W       = 48,
  parameter int PA_W       = 52,
  parameter int OUT_VA_W   = 64,
  parameter int WK_ADDR_W  = 64,
  parameter int SZ_W       = 8,
  parameter int WALK_BYTES = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_ready,
  input logic                 wk_req_valid,
  input logic                 wk_req_ready,
  input logic                 wk_req_stage2,
  input logic [WK_ADDR_W-1:0] wk_req_addr,
  input logic                 wk_req_aligned,
  input logic [SZ_W-1:0]      wk_req_size,
  input logic                 wk_req_s1walk,
  input logic                 dbg_req_valid,
  input logic [2:0]           dbg_req_kind,
  input logic                 res_valid,
  input logic                 res_ready,
  input logic [PA_W-1:0]      res_paddr,
  input logic                 res_ns,
  input logic [2:0]           res_fault,
  input logic [OUT_VA_W-1:0]  res_vaddr
);
  // R1
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_req_valid || dbg_req_valid || res_valid) |-> !req_ready);

  // R1
  one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wk_req_valid, dbg_req_valid, res_valid}));

  // R1
  walker_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_req_valid && !wk_req_ready) |=>
      (wk_req_valid && $stable(wk_req_addr) && $stable(wk_req_stage2)));

  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_paddr) && $stable(res_ns) &&
       $stable(res_fault) && $stable(res_vaddr)));

  // R10
  walk_lookup_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_req_valid && wk_req_s1walk) |->
      (wk_req_stage2 && wk_req_aligned && wk_req_size == SZ_W'(WALK_BYTES)));

  // R11
  dbg_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req_valid |-> (dbg_req_kind != 3'd4 && dbg_req_kind != 3'd5 &&
                       dbg_req_kind != 3'd6));

  // R12
  vaddr_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_vaddr >> VA_W) == '0));
endmodule

bind xlate_seq xlate_seq_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .OUT_VA_W(OUT_VA_W),
  .WK_ADDR_W(WK_ADDR_W), .SZ_W(SZ_W), .WALK_BYTES(WALK_BYTES)
) u_chk (.*);

// File: tb/xlate_seq_bench.sv
`timescale 1ns/1ps
module xlate_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cfg_s2_present = 0, cfg_s2_virt_en = 0, cfg_s2_dflt_cache = 0, cfg_walk_protect = 0;
  logic req_valid = 0, req_write = 0, req_aligned = 0, req_ns = 0, req_table_walk = 0;
  logic [47:0] req_vaddr = '0;
  logic [2:0]  req_kind = '0;
  logic [7:0]  req_size = '0;
  logic req_ready;
  logic wk_req_valid, wk_req_stage2, wk_req_ns, wk_req_write, wk_req_aligned, wk_req_s1walk;
  logic wk_req_ready = 0;
  logic [63:0] wk_req_addr;
  logic [2:0]  wk_req_kind;
  logic [7:0]  wk_req_size;
  logic wk_rsp_valid = 0, wk_rsp_ns = 0, wk_rsp_device = 0, wk_rsp_deny = 0;
  logic wk_rsp_ready;
  logic [51:0] wk_rsp_addr = '0;
  logic [2:0]  wk_rsp_fault = '0;
  logic dbg_req_valid, dbg_req_write, dbg_rsp_ready;
  logic dbg_req_ready = 0, dbg_rsp_valid = 0;
  logic [47:0] dbg_req_vaddr;
  logic [2:0]  dbg_req_kind;
  logic [7:0]  dbg_req_size;
  logic [2:0]  dbg_rsp_fault = '0;
  logic res_valid, res_ns;
  logic res_ready = 0;
  logic [51:0] res_paddr;
  logic [2:0]  res_fault;
  logic [63:0] res_vaddr;

  xlate_seq u_xlate_seq (.*);

  typedef struct {
    logic [2:0] kind; logic wr; logic aligned; logic walk; logic [7:0] size;
    logic [47:0] va; logic ns;
    logic [51:0] s1_pa; logic s1_ns; logic [2:0] s1_f; logic s1_dev; logic s1_deny;
    logic [51:0] s2_pa; logic s2_ns; logic [2:0] s2_f; logic s2_dev; logic s2_deny;
    logic [2:0] dbg_f;
    logic present; logic vm; logic dc; logic ptwp;
  } txn_t;

  typedef struct {
    logic [51:0] pa; logic ns; logic [2:0] f; logic [63:0] va; string tag;
  } exp_t;

  exp_t sb_q[$];
  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic txn_t base();
    txn_t t;
    t.kind = 3'd0; t.wr = 0; t.aligned = 1; t.walk = 0; t.size = 8'd4;
    t.va = 48'h0000_1234_5670; t.ns = 0;
    t.s1_pa = 52'h0_00AB_CDEF_0000; t.s1_ns = 1; t.s1_f = 0; t.s1_dev = 0; t.s1_deny = 0;
    t.s2_pa = 52'h0_0077_0000_1000; t.s2_ns = 0; t.s2_f = 0; t.s2_dev = 0; t.s2_deny = 0;
    t.dbg_f = 0; t.present = 1; t.vm = 1; t.dc = 0; t.ptwp = 0;
    return t;
  endfunction

  // driver: computes the expectation, plays the walker and debug checker
  task automatic run(input txn_t t, input string tag);
    exp_t e;
    logic [51:0] ipa; logic ns; logic [2:0] f; logic s2go, dbgx, al;
    int saw_s1 = 0, saw_s2 = 0, saw_dbg = 0;
    ipa = t.walk ? 52'(t.va) : t.s1_pa;
    ns  = t.walk ? t.ns : t.s1_ns;
    f   = t.walk ? 3'd0 : t.s1_f;
    s2go = (f == 0) && (t.kind != 3'd3) && t.present && (t.vm || t.dc);
    e.pa = ipa; e.ns = ns;
    if (s2go) begin
      al = t.walk | t.aligned;
      f = t.s2_f;
      if (f == 0 && t.s2_dev && ((!al && t.kind != 3'd1) || t.kind == 3'd2)) f = 3'd2;
      if (f == 0 && t.s2_deny) f = 3'd3;
      if (f == 0 && !t.walk && t.s2_dev && t.kind == 3'd1) f = 3'd4;
      if (f == 0 && t.walk && t.ptwp && t.s2_dev) f = 3'd3;
      e.pa = t.s2_pa; e.ns = t.s2_ns;
    end
    dbgx = (f == 0) && !(t.kind inside {3'd4, 3'd5, 3'd6});
    if (dbgx) f = t.dbg_f;
    e.f = f; e.va = 64'(t.va); e.tag = tag;
    sb_q.push_back(e);

    @(negedge clk);
    cfg_s2_present = t.present; cfg_s2_virt_en = t.vm;
    cfg_s2_dflt_cache = t.dc; cfg_walk_protect = t.ptwp;
    req_valid = 1; req_vaddr = t.va; req_kind = t.kind; req_write = t.wr;
    req_aligned = t.aligned; req_size = t.size; req_ns = t.ns; req_table_walk = t.walk;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!res_valid) begin
      if (wk_req_valid) begin
        // R1: no new request taken while busy
        chk(!req_ready, {"R1 busy ", tag}, 64'(req_ready), 64'd0);
        if (!wk_req_stage2) begin
          saw_s1++;
          // R5: stage-1 lookup uses the zero-extended virtual address
          chk(wk_req_addr == 64'(t.va), {"R5 s1 addr ", tag}, wk_req_addr, 64'(t.va));
        end else begin
          saw_s2++;
          // R5: intermediate address and secure bit carried into stage 2
          chk(wk_req_addr == 64'(ipa) && wk_req_ns == ns, {"R5 s2 addr ", tag},
              {wk_req_ns, wk_req_addr[62:0]}, {ns, 63'(ipa)});
          if (t.walk)  // R10: walk lookups are aligned 8-byte accesses
            chk(wk_req_aligned && wk_req_size == 8'd8 && wk_req_s1walk,
                {"R10 shape ", tag}, {wk_req_aligned, wk_req_size}, {1'b1, 8'd8});
        end
        wk_req_ready = 1;
        @(negedge clk);
        wk_req_ready = 0;
        if (!wk_req_stage2 && saw_s2 == 0 && saw_s1 > 0 && wk_rsp_ready) begin end
        if (saw_s2 > 0) begin
          wk_rsp_addr = t.s2_pa; wk_rsp_ns = t.s2_ns; wk_rsp_fault = t.s2_f;
          wk_rsp_device = t.s2_dev; wk_rsp_deny = t.s2_deny;
        end else begin
          wk_rsp_addr = t.s1_pa; wk_rsp_ns = t.s1_ns; wk_rsp_fault = t.s1_f;
          wk_rsp_device = t.s1_dev; wk_rsp_deny = t.s1_deny;
        end
        wk_rsp_valid = 1;
        @(negedge clk);
        wk_rsp_valid = 0;
      end else if (dbg_req_valid) begin
        saw_dbg++;
        chk(dbg_req_vaddr == t.va, {"R11 dbg addr ", tag}, 64'(dbg_req_vaddr), 64'(t.va));
        dbg_req_ready = 1;
        @(negedge clk);
        dbg_req_ready = 0;
        dbg_rsp_fault = t.dbg_f; dbg_rsp_valid = 1;
        @(negedge clk);
        dbg_rsp_valid = 0;
      end else begin
        @(negedge clk);
      end
    end
    // R10: stage 1 skipped exactly for walk lookups
    chk(saw_s1 == (t.walk ? 0 : 1), {"R10 s1 count ", tag}, 64'(saw_s1), t.walk ? 64'd0 : 64'd1);
    // R3 / R4: stage 2 issued or skipped as configured
    chk(saw_s2 == (s2go ? 1 : 0), {"R3/R4 s2 count ", tag}, 64'(saw_s2), 64'(s2go));
    // R11: debug check gating
    chk(saw_dbg == (dbgx ? 1 : 0), {"R11 dbg count ", tag}, 64'(saw_dbg), 64'(dbgx));
    while (res_valid) @(negedge clk);
  endtask

  // monitor: pops the scoreboard on each result, stalls it to test the hold
  initial begin
    forever begin
      @(negedge clk);
      if (res_valid) begin
        exp_t e;
        logic [51:0] pa0; logic [2:0] f0; logic [63:0] va0; logic ns0;
        pa0 = res_paddr; f0 = res_fault; va0 = res_vaddr; ns0 = res_ns;
        if (sb_q.size() == 0) begin
          chk(1'b0, "R2 unexpected result", 64'(f0), 64'd0);
        end else begin
          e = sb_q.pop_front();
          chk(f0 == e.f, {"R6-R9/R11 fault ", e.tag}, 64'(f0), 64'(e.f));
          chk(pa0 == e.pa && ns0 == e.ns, {"R3/R13 paddr ", e.tag},
              {11'd0, ns0, pa0}, {11'd0, e.ns, e.pa});
          chk(va0 == e.va, {"R12 vaddr ", e.tag}, va0, e.va);
        end
        @(negedge clk);
        @(negedge clk);
        // R2: stalled result unchanged
        chk(res_valid && res_paddr == pa0 && res_fault == f0 && res_vaddr == va0,
            "R2 hold", {res_valid, 60'(res_fault)}, {1'b1, 60'(f0)});
        res_ready = 1;
        @(negedge clk);
        res_ready = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    txn_t t;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready && !res_valid && !wk_req_valid && !dbg_req_valid, "R1 reset",
        {req_ready, res_valid, wk_req_valid}, 64'b100);
    rst_n = 1;
    @(negedge clk);

    t = base(); run(t, "clean load");                                   // R4 R5 R11 R12
    t = base(); t.va = 48'hFFFF_FFFF_FFF8; t.wr = 1; run(t, "top va");  // R12
    t = base(); t.s1_f = 3'd1; run(t, "s1 fault");                      // R3
    t = base(); t.kind = 3'd3; run(t, "nv reg");                        // R3
    t = base(); t.present = 0; run(t, "no s2");                         // R3
    t = base(); t.vm = 0; t.dc = 1; run(t, "dc enables");               // R4
    t = base(); t.vm = 0; t.dc = 0; run(t, "s2 off");                   // R4
    t = base(); t.aligned = 0; t.s2_dev = 1; t.s2_deny = 1; run(t, "misalign dev");  // R6
    t = base(); t.kind = 3'd2; t.s2_dev = 1; run(t, "zero line dev");   // R6
    t = base(); t.aligned = 0; run(t, "misalign normal mem");           // R6
    t = base(); t.kind = 3'd1; t.aligned = 0; t.s2_dev = 1; run(t, "fetch dev");     // R8
    t = base(); t.s2_deny = 1; run(t, "deny");                          // R7
    t = base(); t.s2_f = 3'd1; t.s2_deny = 1; t.s2_dev = 1; t.aligned = 0;
    run(t, "s2 walk fault first");                                      // R6 R7
    t = base(); t.walk = 1; t.kind = 3'd4; t.aligned = 0; t.size = 8'd2;
    t.s2_dev = 1; t.ptwp = 1; run(t, "walk protect");                   // R9 R10
    t = base(); t.walk = 1; t.kind = 3'd4; t.s2_dev = 1; run(t, "walk dev ok");      // R9 R11
    t = base(); t.walk = 1; t.kind = 3'd1; t.s2_dev = 1; run(t, "walk fetch dev");   // R8
    t = base(); t.walk = 1; t.kind = 3'd4; t.ns = 1; t.present = 0; t.va = 48'h0000_0ABC_D000;
    run(t, "walk passthrough");                                         // R10
    t = base(); t.vm = 0; t.s1_dev = 1; t.s1_deny = 1; run(t, "s1 flags ignored");   // R13
    t = base(); t.dbg_f = 3'd5; run(t, "debug fault");                  // R11
    t = base(); t.kind = 3'd5; t.dbg_f = 3'd5; run(t, "ic maint");      // R11
    t = base(); t.kind = 3'd6; t.dbg_f = 3'd5; run(t, "addr xlate");    // R11

    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R2 scoreboard drained", 64'(sb_q.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule